// File: doc/BRIEF.md
# Dual-Edge 1:8 Serial-to-Parallel Converter

This block turns a serial bit stream into parallel words. Its clock runs at half the bit rate and the serial input is captured on both clock edges: the rising edge takes one bit and the following falling edge takes the next. For the 8-bit default this means a 1.25 Gbps stream is handled with a 625 MHz clock, and a new 8-bit word appears at 156.25 MHz.

Bits taken on rising edges fill one short shift chain and bits taken on falling edges fill a second chain. Once every word period, which is four clock periods at the default width, the two chains are interleaved into a word. That word is loaded into the output register and a strobe marks it. The first bit captured after reset is the first bit of the first word, and the framing never changes after that. The block does not recover the clock, search for a frame marker or decode the data.

Top module: `ddr_deser`

## Requirements
- R1: The bit present at a rising edge and the bit present at the following falling edge are stored as consecutive word bits, with the rising-edge bit first. The stream therefore carries two bits per clock period.
- R2: Bit i of `data_o` is the i-th bit received within its word, counting from 0. Bit 0 is the first bit received and bit WORD_W-1 the last. For example, receiving 1,1,0,1,0,1,1,0 in that order gives `data_o` = 8'h6B.
- R3: `valid_o` is high for exactly one clock period per word. While bits keep arriving, successive pulses are WORD_W/2 clock periods apart.
- R4: After reset is released, the bit sampled at the first rising edge is bit 0 of the first word. That word appears, with `valid_o` high, right after rising edge number WORD_W/2+1.
- R5: `data_o` changes only in the period where `valid_o` is high, and holds its value through every other period.
- R6: When `rst_ni` goes low, `data_o` and `valid_o` clear at once without waiting for a clock edge. The capture chains and the word counter clear too, so framing restarts at R4.
- R7: Words follow one another with no gap. The bit at the rising edge where a word is loaded is bit 0 of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-bit-rate clock; both edges sample `ser_i` |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data in |
| data_o | output | WORD_W | Assembled word, bit 0 received first |
| valid_o | output | 1 | One-clock strobe when `data_o` loads a new word |

## Verification
The bench builds the block with WORD_W = 8. With that width each chain holds four bits and the phase counter is two bits wide, so a word takes only four clock periods. Every wrap of the counter, the five-edge latency of the first word, and the back-to-back hand-off from one word to the next therefore occur many times within a short run. The bench also asserts reset in the middle of a word to show that framing restarts from the first bit captured after release.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;
  parameter int unsigned DSER_WORD_W_DEF = 8;

  function automatic int unsigned phase_bits(input int unsigned half_w);
    return (half_w > 1) ? $clog2(half_w) : 1;
  endfunction
endpackage

// File: rtl/edge_shift_chain.sv
module edge_shift_chain #(
  parameter int unsigned DEPTH    = 4,
  parameter bit          FALL_EDGE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [DEPTH-1:0] chain_o
);
  logic [DEPTH-1:0] chain_q;

  // newest bit enters at the top, so index 0 holds the oldest after DEPTH shifts
  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {ser_i, chain_q[DEPTH-1:1]};
      end
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {ser_i, chain_q[DEPTH-1:1]};
      end
    end
  endgenerate

  assign chain_o = chain_q;
endmodule

// File: rtl/word_phase_cnt.sv
module word_phase_cnt #(
  parameter int unsigned HALF_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o
);
  localparam int unsigned CNT_W = ddr_deser_pkg::phase_bits(HALF_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // first edge after reset starts a word, it does not close one
  assign load_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/chain_interleave.sv
module chain_interleave #(
  parameter int unsigned HALF_W = 4
) (
  input  logic [HALF_W-1:0]   rise_i,
  input  logic [HALF_W-1:0]   fall_i,
  output logic [2*HALF_W-1:0] word_o
);
  for (genvar k = 0; k < HALF_W; k++) begin : g_pair
    assign word_o[2*k]   = rise_i[k];
    assign word_o[2*k+1] = fall_i[k];
  end
endmodule

// File: rtl/ddr_deser.sv
module ddr_deser #(
  parameter int unsigned WORD_W = ddr_deser_pkg::DSER_WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  localparam int unsigned HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] rise_chain, fall_chain;
  logic [WORD_W-1:0] merged;
  logic              load;

  edge_shift_chain #(.DEPTH(HALF_W), .FALL_EDGE(1'b0)) i_rise_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .chain_o(rise_chain)
  );

  edge_shift_chain #(.DEPTH(HALF_W), .FALL_EDGE(1'b1)) i_fall_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .chain_o(fall_chain)
  );

  word_phase_cnt #(.HALF_W(HALF_W)) i_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_o(load)
  );

  chain_interleave #(.HALF_W(HALF_W)) i_merge (
    .rise_i(rise_chain), .fall_i(fall_chain), .word_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load;
      if (load) data_o <= merged;
    end
  end
endmodule

// File: rtl/ddr_deser_chk.sv
module ddr_deser_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] data_o,
  input logic              valid_o
);
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned GAP_W  = $clog2(HALF_W + 2) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (valid_o) seen_q <= 1'b1;
      gap_q <= valid_o ? '0 : ((gap_q == '1) ? gap_q : gap_q + 1'b1);
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r3_pulse_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> (gap_q == GAP_W'(HALF_W - 1)));

  a_r4_first_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !seen_q) |-> (gap_q == GAP_W'(HALF_W + 1)));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  always @(negedge clk_i) begin
    if (!rst_ni) a_r6_reset_clear: assert (data_o == '0 && !valid_o);
  end
endmodule

bind ddr_deser ddr_deser_chk #(.WORD_W(WORD_W)) i_ddr_deser_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_o(data_o), .valid_o(valid_o)
);

// File: tb/test_ddr_deser.sv
module test_ddr_deser;
  localparam int unsigned W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ser_i = 1'b0;
  logic [W-1:0] data_o;
  logic         valid_o;

  int checks = 0, failures = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_word;
  int since_valid;
  bit first_after_rst;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ddr_deser #(.WORD_W(W)) i_ddr_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .data_o(data_o), .valid_o(valid_o)
  );

  function automatic logic [W-1:0] expect_word(input logic [W-1:0] sent);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = sent[i]; // i-th bit sent lands at index i
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // entered at negedge+5, leaves at negedge+5
  task automatic send_word(input logic [W-1:0] w);
    exp_q.push_back(expect_word(w));
    for (int k = 0; k < W / 2; k++) begin
      ser_i = w[2*k];
      @(posedge clk_i); #5;
      ser_i = w[2*k+1];
      @(negedge clk_i); #5;
    end
  endtask

  task automatic release_reset();
    @(negedge clk_i); #2;
    rst_ni = 1'b1;
    #3;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      since_valid = 0;
      first_after_rst = 1'b1;
      last_word = '0;
    end else begin
      since_valid++;
      if (valid_o) begin
        if (first_after_rst)
          check(since_valid == W / 2 + 1, "R4 first word latency", W'(since_valid), W'(W / 2 + 1));
        else
          check(since_valid == W / 2, "R3 R7 pulse spacing", W'(since_valid), W'(W / 2));
        first_after_rst = 1'b0;
        since_valid = 0;
        if (exp_q.size() > 0) begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(data_o == e, "R1 R2 word content", data_o, e);
        end
        last_word = data_o;
      end else begin
        check(data_o == last_word, "R5 hold between words", data_o, last_word);
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #3;
    check(data_o == '0 && valid_o == 1'b0, "R6 reset state", data_o, '0);
    release_reset();
    send_word(8'h6B);
    send_word(8'h6B);
    send_word(8'h00);
    send_word(8'hFF);
    send_word(8'hAA);
    send_word(8'h55);
    for (int n = 0; n < 40; n++) send_word(W'($urandom));
    // mid-word reset
    ser_i = 1'b1;
    @(posedge clk_i); #5;
    rst_ni = 1'b0;
    #1;
    check(data_o == '0 && valid_o == 1'b0, "R6 async clear", data_o, '0);
    exp_q.delete();
    repeat (3) @(posedge clk_i);
    release_reset();
    send_word(8'h6B);
    send_word(8'h81);
    for (int n = 0; n < 40; n++) send_word(W'($urandom));
    repeat (W) @(posedge clk_i);
    check(exp_q.size() == 0, "R7 all words delivered", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule